// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block caches virtual-to-physical page translations in a small fully associative table. Each slot carries a virtual page tag, an address-space number, a global flag that lets the slot serve every address space, a physical page number, per-privilege-mode read and write enable masks, and two fault-on-access flags (one for reads, one for writes). A lookup presents a virtual address and the current address-space number. In the same cycle it returns hit, the slot index, the physical address and the slot's permission fields.

Pages are 8 KiB. The virtual page number is the address shifted right by 13, and the low 13 address bits pass straight through into the physical address. New translations fill the slot named by a round-robin victim pointer. A read port shows the victim slot and can step the pointer. Three invalidation strobes are provided: flush everything, flush every non-global slot, and flush the slots that match one address.

A three-deep shortcut list remembers the slots that recent full searches found. It is consulted before the full search, so the slot it names wins over a lower-numbered duplicate. Any insert or flush empties it.

Top module: `asn_tlb`

## Requirements
- R1: A slot matches only when it is valid, its tag equals req_vaddr>>13, and either its global flag is set or its stored space number equals req_asn. On a hit, lk_pa = {ppn, req_vaddr[12:0]}, and lk_glob, lk_rd_en, lk_wr_en, lk_fonr and lk_fonw are the slot's fields. Without a hit, lk_hit and all lk_* outputs are 0.
- R2: A lookup first checks the shortcut slots, newest first. If one matches, lk_recent=1 and lk_idx names that slot. Otherwise the lowest-numbered matching slot is returned with lk_recent=0, and it is pushed to the front of the list. The list keeps at most three indices and drops the oldest.
- R3: Any insert, flush-all, flush-non-global or flush-by-address strobe empties the shortcut list, so the next lookup reports lk_recent=0.
- R4: An insert writes the slot at vic_idx with tag req_vaddr>>13, space number req_asn and the ins_* fields, marks it valid, and advances vic_idx. After the last slot, vic_idx returns to 0.
- R5: Flush-all clears every field of every slot to zero and sets vic_idx to 0.
- R6: Flush-non-global marks invalid every slot whose global flag is clear. Global slots still hit, and the stored tags of the cleared slots are kept.
- R7: Flush-by-address marks invalid every slot that matches req_vaddr and req_asn by the R1 rule. Other slots are untouched.
- R8: vic_valid, vic_vpn and vic_ppn show the slot at vic_idx. vic_adv steps vic_idx by one with wrap-around, and never more than one step per cycle.
- R9: Flush-all beats flush-non-global, which beats flush-by-address. Any flush beats insert, and insert beats lookup. A lookup that is overruled reports lk_hit=0. vic_adv is ignored in a cycle that carries a flush or an insert.
- R10: After reset, every slot is invalid with zero fields, vic_idx is 0, the shortcut list is empty, and lookups miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vaddr | input | 29 | Virtual address for lookup, insert and flush-by-address |
| req_asn | input | 8 | Current address-space number |
| lk_en | input | 1 | Lookup request |
| ins_en | input | 1 | Insert at victim slot |
| ins_glob | input | 1 | Global flag of the new slot |
| ins_ppn | input | 16 | Physical page of the new slot |
| ins_rd_en | input | 4 | Per-mode read enables of the new slot |
| ins_wr_en | input | 4 | Per-mode write enables of the new slot |
| ins_fonr | input | 1 | Fault-on-read flag of the new slot |
| ins_fonw | input | 1 | Fault-on-write flag of the new slot |
| fl_all | input | 1 | Flush every slot |
| fl_nonglob | input | 1 | Flush non-global slots |
| fl_addr | input | 1 | Flush slots matching req_vaddr/req_asn |
| vic_adv | input | 1 | Step the victim pointer |
| lk_hit | output | 1 | Lookup hit |
| lk_recent | output | 1 | Hit came from the shortcut list |
| lk_idx | output | 3 | Index of the hit slot |
| lk_pa | output | 29 | Translated physical address |
| lk_glob | output | 1 | Global flag of the hit slot |
| lk_rd_en | output | 4 | Read enables of the hit slot |
| lk_wr_en | output | 4 | Write enables of the hit slot |
| lk_fonr | output | 1 | Fault-on-read of the hit slot |
| lk_fonw | output | 1 | Fault-on-write of the hit slot |
| vic_idx | output | 3 | Victim pointer |
| vic_valid | output | 1 | Valid bit of the victim slot |
| vic_vpn | output | 16 | Tag of the victim slot |
| vic_ppn | output | 16 | Physical page of the victim slot |

## Verification
The collisions that matter are a flush landing in the same cycle as an insert, and an insert landing on a lookup. The bench raises those strobes together, along with vic_adv. The reference model applies the priority order, so the bench expects a forced miss, an unchanged victim slot or a single pointer step. The outcome is judged on the victim port and on later lookups. The shortcut list is also tested against a duplicate translation: a global slot and a space-specific slot share one tag, the cached index must beat the lower-numbered one, and that must stop the moment an insert or flush clears the list.

// File: rtl/asn_tlb_pkg.sv
package asn_tlb_pkg;
  parameter int VPN_W    = 16;
  parameter int ASN_W    = 8;
  parameter int PPN_W    = 16;
  parameter int MODE_N   = 4;
  parameter int PG_SHIFT = 13;
  localparam int VA_W    = VPN_W + PG_SHIFT;
  localparam int PA_W    = PPN_W + PG_SHIFT;

  typedef struct packed {
    logic              vld;
    logic [VPN_W-1:0]  vpn;
    logic [ASN_W-1:0]  asn;
    logic              glob;
    logic [PPN_W-1:0]  ppn;
    logic [MODE_N-1:0] rd_en;
    logic [MODE_N-1:0] wr_en;
    logic              fonr;
    logic              fonw;
  } tlb_ent_t;
endpackage

// File: rtl/asn_tlb_match.sv
module asn_tlb_match
  import asn_tlb_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  tlb_ent_t [ENTRIES-1:0] ents,
  input  logic [VPN_W-1:0]       vpn,
  input  logic [ASN_W-1:0]       asn,
  output logic [ENTRIES-1:0]     hit_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = ents[g].vld && (ents[g].vpn == vpn) &&
                        (ents[g].glob || (ents[g].asn == asn));
  end
endmodule

// File: rtl/asn_tlb_victim.sv
module asn_tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);
  logic [IDX_W-1:0] ptr_n;
  logic             ptr_we;

  always_comb begin
    ptr_we = clear | step;
    if (clear)
      ptr_n = '0;
    else if (ptr == IDX_W'(ENTRIES - 1))
      ptr_n = '0;
    else
      ptr_n = ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= '0;
    else if (ptr_we)
      ptr <= ptr_n;
  end
endmodule

// File: rtl/asn_tlb_recent.sv
module asn_tlb_recent #(
  parameter int ENTRIES = 8,
  parameter int DEPTH   = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               lk_go,
  input  logic [ENTRIES-1:0] hit_vec,
  output logic               hit,
  output logic               from_rc,
  output logic [IDX_W-1:0]   idx
);
  logic [DEPTH-1:0]             rc_v,   rc_v_n;
  logic [DEPTH-1:0][IDX_W-1:0]  rc_idx, rc_idx_n;
  logic                         rc_hit, fs_hit, promote, rc_we;
  logic [IDX_W-1:0]             rc_sel, fs_idx;

  // shortcut check, slot 0 (newest) wins
  always_comb begin
    rc_hit = 1'b0;
    rc_sel = '0;
    for (int s = DEPTH - 1; s >= 0; s--) begin
      if (rc_v[s] && hit_vec[rc_idx[s]]) begin
        rc_hit = 1'b1;
        rc_sel = rc_idx[s];
      end
    end
  end

  // full search, lowest index wins
  always_comb begin
    fs_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) fs_idx = IDX_W'(i);
    end
  end

  assign fs_hit  = |hit_vec;
  assign hit     = lk_go & fs_hit;
  assign from_rc = lk_go & rc_hit;
  assign idx     = !hit ? '0 : (rc_hit ? rc_sel : fs_idx);
  assign promote = hit & ~rc_hit;
  assign rc_we   = clear | promote;

  always_comb begin
    rc_v_n   = rc_v;
    rc_idx_n = rc_idx;
    if (clear) begin
      rc_v_n = '0;
    end else if (promote) begin
      rc_v_n[0]   = 1'b1;
      rc_idx_n[0] = fs_idx;
      for (int s = 1; s < DEPTH; s++) begin
        rc_v_n[s]   = rc_v[s-1];
        rc_idx_n[s] = rc_idx[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_v   <= '0;
      rc_idx <= '0;
    end else if (rc_we) begin
      rc_v   <= rc_v_n;
      rc_idx <= rc_idx_n;
    end
  end
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
  import asn_tlb_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int RC_DEPTH = 3,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [ASN_W-1:0]  req_asn,
  input  logic              lk_en,
  input  logic              ins_en,
  input  logic              ins_glob,
  input  logic [PPN_W-1:0]  ins_ppn,
  input  logic [MODE_N-1:0] ins_rd_en,
  input  logic [MODE_N-1:0] ins_wr_en,
  input  logic              ins_fonr,
  input  logic              ins_fonw,
  input  logic              fl_all,
  input  logic              fl_nonglob,
  input  logic              fl_addr,
  input  logic              vic_adv,
  output logic              lk_hit,
  output logic              lk_recent,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [PA_W-1:0]   lk_pa,
  output logic              lk_glob,
  output logic [MODE_N-1:0] lk_rd_en,
  output logic [MODE_N-1:0] lk_wr_en,
  output logic              lk_fonr,
  output logic              lk_fonw,
  output logic [IDX_W-1:0]  vic_idx,
  output logic              vic_valid,
  output logic [VPN_W-1:0]  vic_vpn,
  output logic [PPN_W-1:0]  vic_ppn
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= '0;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  tlb_ent_t [ENTRIES-1:0] ents, ents_n;
  logic [ENTRIES-1:0]     hit_vec;
  logic [VPN_W-1:0]       req_vpn;
  logic                   fl_any, do_ins, do_lk, vic_step, ent_we, rc_clear;
  tlb_ent_t               new_ent, hit_ent, vic_ent;

  assign req_vpn  = req_vaddr[VA_W-1:PG_SHIFT];
  assign fl_any   = fl_all | fl_nonglob | fl_addr;
  assign do_ins   = ins_en & ~fl_any;
  assign do_lk    = lk_en & ~fl_any & ~ins_en;
  assign vic_step = do_ins | (vic_adv & ~fl_any & ~ins_en);
  assign ent_we   = fl_any | ins_en;
  assign rc_clear = fl_any | ins_en;

  asn_tlb_match #(.ENTRIES(ENTRIES)) u_match (
    .ents    (ents),
    .vpn     (req_vpn),
    .asn     (req_asn),
    .hit_vec (hit_vec)
  );

  asn_tlb_recent #(.ENTRIES(ENTRIES), .DEPTH(RC_DEPTH)) u_recent (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clear   (rc_clear),
    .lk_go   (do_lk),
    .hit_vec (hit_vec),
    .hit     (lk_hit),
    .from_rc (lk_recent),
    .idx     (lk_idx)
  );

  asn_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clear (fl_all),
    .step  (vic_step),
    .ptr   (vic_idx)
  );

  always_comb begin
    new_ent       = '0;
    new_ent.vld   = 1'b1;
    new_ent.vpn   = req_vpn;
    new_ent.asn   = req_asn;
    new_ent.glob  = ins_glob;
    new_ent.ppn   = ins_ppn;
    new_ent.rd_en = ins_rd_en;
    new_ent.wr_en = ins_wr_en;
    new_ent.fonr  = ins_fonr;
    new_ent.fonw  = ins_fonw;
  end

  // next state of the slot array, in priority order
  always_comb begin
    ents_n = ents;
    if (fl_all) begin
      ents_n = '0;
    end else if (fl_nonglob) begin
      for (int i = 0; i < ENTRIES; i++)
        if (!ents[i].glob) ents_n[i].vld = 1'b0;
    end else if (fl_addr) begin
      for (int i = 0; i < ENTRIES; i++)
        if (hit_vec[i]) ents_n[i].vld = 1'b0;
    end else if (do_ins) begin
      ents_n[vic_idx] = new_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)
      ents <= '0;
    else if (ent_we)
      ents <= ents_n;
  end

  assign hit_ent   = lk_hit ? ents[lk_idx] : '0;
  assign lk_pa     = lk_hit ? {hit_ent.ppn, req_vaddr[PG_SHIFT-1:0]} : '0;
  assign lk_glob   = hit_ent.glob;
  assign lk_rd_en  = hit_ent.rd_en;
  assign lk_wr_en  = hit_ent.wr_en;
  assign lk_fonr   = hit_ent.fonr;
  assign lk_fonw   = hit_ent.fonw;

  assign vic_ent   = ents[vic_idx];
  assign vic_valid = vic_ent.vld;
  assign vic_vpn   = vic_ent.vpn;
  assign vic_ppn   = vic_ent.ppn;
endmodule

// File: rtl/asn_tlb_chk.sv
module asn_tlb_chk #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_en,
  input logic             ins_en,
  input logic             fl_all,
  input logic             fl_nonglob,
  input logic             fl_addr,
  input logic             vic_adv,
  input logic             lk_hit,
  input logic             lk_recent,
  input logic [IDX_W-1:0] vic_idx
);
  logic fl_any;
  assign fl_any = fl_all | fl_nonglob | fl_addr;

  p_hit_unblocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_en && !ins_en && !fl_any));

  p_recent_is_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_recent |-> lk_hit);

  p_list_emptied_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en || fl_any) |=> !lk_recent);

  p_flush_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_all |=> (vic_idx == '0));

  p_insert_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && !fl_any) |=>
      (vic_idx == (($past(vic_idx) == IDX_W'(ENTRIES - 1)) ? '0 : $past(vic_idx) + 1'b1)));

  p_adv_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_adv && !ins_en && !fl_any) |=>
      (vic_idx == (($past(vic_idx) == IDX_W'(ENTRIES - 1)) ? '0 : $past(vic_idx) + 1'b1)));

  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!vic_adv && !ins_en && !fl_all) |=> $stable(vic_idx));
endmodule

bind asn_tlb asn_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .lk_en      (lk_en),
  .ins_en     (ins_en),
  .fl_all     (fl_all),
  .fl_nonglob (fl_nonglob),
  .fl_addr    (fl_addr),
  .vic_adv    (vic_adv),
  .lk_hit     (lk_hit),
  .lk_recent  (lk_recent),
  .vic_idx    (vic_idx)
);

// File: tb/asn_tlb_test.sv
module asn_tlb_test;
  localparam int CLK_P = 10;
  localparam int N     = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [28:0] req_vaddr;
  logic [7:0]  req_asn;
  logic        lk_en, ins_en, ins_glob, ins_fonr, ins_fonw;
  logic [15:0] ins_ppn;
  logic [3:0]  ins_rd_en, ins_wr_en;
  logic        fl_all, fl_nonglob, fl_addr, vic_adv;
  logic        lk_hit, lk_recent, lk_glob, lk_fonr, lk_fonw, vic_valid;
  logic [2:0]  lk_idx, vic_idx;
  logic [28:0] lk_pa;
  logic [3:0]  lk_rd_en, lk_wr_en;
  logic [15:0] vic_vpn, vic_ppn;

  always #(CLK_P/2) clk = ~clk;

  asn_tlb uut (
    .clk(clk), .rst_n(rst_n), .req_vaddr(req_vaddr), .req_asn(req_asn),
    .lk_en(lk_en), .ins_en(ins_en), .ins_glob(ins_glob), .ins_ppn(ins_ppn),
    .ins_rd_en(ins_rd_en), .ins_wr_en(ins_wr_en), .ins_fonr(ins_fonr),
    .ins_fonw(ins_fonw), .fl_all(fl_all), .fl_nonglob(fl_nonglob),
    .fl_addr(fl_addr), .vic_adv(vic_adv), .lk_hit(lk_hit),
    .lk_recent(lk_recent), .lk_idx(lk_idx), .lk_pa(lk_pa),
    .lk_glob(lk_glob), .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en),
    .lk_fonr(lk_fonr), .lk_fonw(lk_fonw), .vic_idx(vic_idx),
    .vic_valid(vic_valid), .vic_vpn(vic_vpn), .vic_ppn(vic_ppn)
  );

  // behavioural reference model
  int m_vld[N], m_vpn[N], m_asn[N], m_glob[N], m_ppn[N];
  int m_rd[N], m_wr[N], m_fr[N], m_fw[N];
  int m_ptr;
  int m_rq[$];

  int  n_cmp = 0, n_bad = 0;
  bit  done  = 1'b0;

  function automatic bit mt(int i);
    return (m_vld[i] != 0) && (m_vpn[i] == int'(req_vaddr >> 13)) &&
           ((m_glob[i] != 0) || (m_asn[i] == int'(req_asn)));
  endfunction

  task automatic model_clear_all();
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_vpn[i] = 0; m_asn[i] = 0; m_glob[i] = 0; m_ppn[i] = 0;
      m_rd[i] = 0; m_wr[i] = 0; m_fr[i] = 0; m_fw[i] = 0;
    end
    m_ptr = 0;
    m_rq.delete();
  endtask

  task automatic model_eval(output bit eh, output int sel, output bit er);
    bit fl;
    fl  = fl_all || fl_nonglob || fl_addr;
    eh  = 1'b0; er = 1'b0; sel = 0;
    if (lk_en && !fl && !ins_en) begin
      foreach (m_rq[k]) if (!eh && mt(m_rq[k])) begin
        eh = 1'b1; er = 1'b1; sel = m_rq[k];
      end
      for (int i = 0; i < N; i++) if (!eh && mt(i)) begin
        eh = 1'b1; sel = i;
      end
    end
  endtask

  task automatic model_step(input bit eh, input int sel, input bit er);
    bit kill[N];
    if (fl_all) begin
      model_clear_all();
    end else if (fl_nonglob) begin
      m_rq.delete();
      for (int i = 0; i < N; i++) if (m_glob[i] == 0) m_vld[i] = 0;
    end else if (fl_addr) begin
      m_rq.delete();
      for (int i = 0; i < N; i++) kill[i] = mt(i);
      for (int i = 0; i < N; i++) if (kill[i]) m_vld[i] = 0;
    end else if (ins_en) begin
      m_rq.delete();
      m_vld[m_ptr] = 1; m_vpn[m_ptr] = int'(req_vaddr >> 13);
      m_asn[m_ptr] = int'(req_asn); m_glob[m_ptr] = int'(ins_glob);
      m_ppn[m_ptr] = int'(ins_ppn); m_rd[m_ptr] = int'(ins_rd_en);
      m_wr[m_ptr] = int'(ins_wr_en); m_fr[m_ptr] = int'(ins_fonr);
      m_fw[m_ptr] = int'(ins_fonw);
      m_ptr = (m_ptr + 1) % N;
    end else begin
      if (vic_adv) m_ptr = (m_ptr + 1) % N;
      if (eh && !er) begin
        m_rq.push_front(sel);
        if (m_rq.size() > 3) void'(m_rq.pop_back());
      end
    end
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    lk_en = 0; ins_en = 0; ins_glob = 0; ins_ppn = '0; ins_rd_en = '0;
    ins_wr_en = '0; ins_fonr = 0; ins_fonw = 0; fl_all = 0;
    fl_nonglob = 0; fl_addr = 0; vic_adv = 0;
  endtask

  // one clock: compare combinational outputs, then advance model
  task automatic cyc(input string tag);
    bit eh, er; int sel, pa;
    #(CLK_P/4);
    model_eval(eh, sel, er);
    chk(tag, "lk_hit", int'(lk_hit), int'(eh));
    if (eh) begin
      pa = (m_ppn[sel] << 13) | int'(req_vaddr & 29'h1fff);
      chk(tag, "lk_idx", int'(lk_idx), sel);
      chk(tag, "lk_recent", int'(lk_recent), int'(er));
      chk(tag, "lk_pa", int'(lk_pa), pa);
      chk(tag, "lk_fields", int'({lk_glob, lk_rd_en, lk_wr_en, lk_fonr, lk_fonw}),
          (m_glob[sel] << 10) | (m_rd[sel] << 6) | (m_wr[sel] << 2) |
          (m_fr[sel] << 1) | m_fw[sel]);
    end else begin
      chk(tag, "lk_pa_zero", int'(lk_pa), 0);
    end
    chk(tag, "vic_idx", int'(vic_idx), m_ptr);
    chk(tag, "vic_valid", int'(vic_valid), m_vld[m_ptr]);
    chk(tag, "vic_vpn", int'(vic_vpn), m_vpn[m_ptr]);
    chk(tag, "vic_ppn", int'(vic_ppn), m_ppn[m_ptr]);
    @(posedge clk);
    #1;
    model_step(eh, sel, er);
    @(negedge clk);
    idle();
  endtask

  task automatic set_req(input int vpn, input int off, input int asn);
    req_vaddr = 29'((vpn << 13) | (off & 32'h1fff));
    req_asn   = 8'(asn);
  endtask

  task automatic put(input int vpn, input int asn, input bit g, input int ppn,
                     input int rd, input int wr, input bit fr, input bit fw);
    set_req(vpn, 0, asn);
    ins_en = 1; ins_glob = g; ins_ppn = 16'(ppn); ins_rd_en = 4'(rd);
    ins_wr_en = 4'(wr); ins_fonr = fr; ins_fonw = fw;
    cyc("R4");
  endtask

  task automatic look(input int vpn, input int off, input int asn, input string tag);
    set_req(vpn, off, asn);
    lk_en = 1;
    cyc(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    set_req(0, 0, 0);
    model_clear_all();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state, lookup misses
    look(0, 0, 0, "R10");
    look(16'h100, 5, 1, "R10");

    // R4: fill all slots; slots 3 and 5 are global
    for (int i = 0; i < N; i++)
      put(16'h100 + i, (i % 2) + 1, (i == 3) || (i == 5), 16'h200 + i,
          i + 1, 15 - i, i[0], i[1]);

    // R1: hits with matching space, global, mismatched space, wrong tag
    for (int i = 0; i < N; i++) look(16'h100 + i, 16 * i + 3, (i % 2) + 1, "R1");
    look(16'h103, 7, 9, "R1");
    look(16'h102, 7, 2, "R1");
    look(16'h1ff, 7, 1, "R1");

    // R2: shortcut behaviour, oldest dropped after three
    look(16'h100, 1, 1, "R2");
    look(16'h101, 1, 2, "R2");
    look(16'h102, 1, 1, "R2");
    look(16'h100, 1, 1, "R2");
    look(16'h104, 1, 1, "R2");

    // R4: wrap-around overwrite of slot 0; then duplicate tag in slot 1
    put(16'h105, 7, 0, 16'h3a0, 1, 2, 0, 0);
    put(16'h105, 7, 0, 16'h3a1, 3, 4, 1, 1);
    look(16'h105, 2, 7, "R2");
    look(16'h105, 2, 9, "R2");
    look(16'h105, 2, 7, "R2");

    // R3: insert empties the list
    look(16'h103, 2, 7, "R3");
    look(16'h103, 2, 7, "R3");
    put(16'h120, 3, 0, 16'h3b0, 1, 1, 0, 0);
    look(16'h103, 2, 7, "R3");
    look(16'h103, 2, 7, "R3");
    fl_addr = 1; set_req(16'h1ee, 0, 0); cyc("R3");
    look(16'h103, 2, 7, "R3");

    // R7: flush by address removes the space match and the global one
    set_req(16'h105, 0, 7); fl_addr = 1; cyc("R7");
    look(16'h105, 4, 7, "R7");
    look(16'h105, 4, 1, "R7");
    set_req(16'h104, 0, 2); fl_addr = 1; cyc("R7");
    look(16'h104, 4, 1, "R7");

    // R8: victim port stepping and wrap
    for (int k = 0; k < N + 2; k++) begin vic_adv = 1; cyc("R8"); end
    cyc("R8");

    // R9: collisions
    set_req(16'h130, 0, 4); ins_en = 1; ins_ppn = 16'h3c0; lk_en = 1; vic_adv = 1; cyc("R9");
    look(16'h130, 9, 4, "R9");
    set_req(16'h131, 0, 4); ins_en = 1; ins_ppn = 16'h3c1; fl_addr = 1; lk_en = 1; cyc("R9");
    look(16'h131, 9, 4, "R9");
    set_req(16'h130, 0, 4); fl_addr = 1; fl_nonglob = 1; vic_adv = 1; cyc("R9");
    look(16'h103, 9, 1, "R9");
    look(16'h130, 9, 4, "R9");

    // R6: refill a few, then drop everything non-global
    put(16'h140, 1, 0, 16'h3d0, 2, 2, 0, 1);
    put(16'h141, 1, 1, 16'h3d1, 4, 4, 1, 0);
    look(16'h140, 0, 1, "R6");
    fl_nonglob = 1; cyc("R6");
    look(16'h140, 0, 1, "R6");
    look(16'h141, 0, 5, "R6");
    look(16'h103, 0, 6, "R6");
    for (int k = 0; k < N; k++) begin vic_adv = 1; cyc("R6"); end

    // R5: flush everything (with a colliding insert)
    set_req(16'h150, 0, 1); fl_all = 1; ins_en = 1; vic_adv = 1; cyc("R5");
    look(16'h103, 0, 1, "R5");
    look(16'h141, 0, 1, "R5");
    for (int k = 0; k < 3; k++) begin vic_adv = 1; cyc("R5"); end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule